// File: doc/BRIEF.md
# SD Data FIFO Transfer Engine

This block carries the data phase of one multi-block card transfer between a 16-word, 32-bit host FIFO and a byte-wide card data port. Software sets a block size and then a block count. Writing the block count loads the remaining byte count with the product of the two values and starts a transfer run. In read mode the engine takes one card byte per cycle while the card says a byte is ready. It packs those bytes into FIFO words, lowest byte first. In write mode it pops FIFO words and sends their bytes to the card one per cycle, lowest byte first.

Transfer runs are triggered, not free-running. A run starts after one of these register accesses: a data read, a data write, a config write or a block-count write. The run moves bytes while it can and then finishes. The finish step checks the remaining count. If the count is zero, it latches completion status and any enabled interrupt causes, and it forces the debug state code to data mode. The debug register also mirrors the FIFO fill level at all times.

The sequencer has four states:
- IDLE waits for a pending trigger. It goes to RUN_RD if the command is a read, otherwise to RUN_WR.
- RUN_RD stays while a byte moves. It goes to FINISH once the count is zero, the card is not ready or the FIFO is full. On that exit it flushes any partial word.
- RUN_WR stays while a byte moves. It goes to FINISH once the count is zero or there is nothing left to send.
- FINISH applies the completion check and goes back to IDLE.

Top module: `sd_fifo_xfer`

## Requirements
- R1: After reset the status register reads 0, the debug register reads 0x0000C60F, irq is 0, and neither card_take nor card_wr_stb is asserted.
- R2: The FIFO holds 16 words. A push into a full FIFO is dropped. A data read from an empty FIFO returns 0 and changes nothing.
- R3: Writing the block-count register (address 4) loads the remaining byte count with block size (address 3) times the written count, and triggers a run.
- R4: In read mode, card bytes are packed with the first byte in bits 7:0 of a word. A word is pushed every 4 bytes. A run that stops with 1 to 3 bytes packed pushes them as a partial word, zero-filled above.
- R5: A read run moves a byte only in a cycle where card_rdy is 1 and the FIFO is not full. A run that stops early leaves the remaining count untouched, and raising card_rdy later moves nothing until the next trigger.
- R6: In write mode each popped word goes to the card as byte 7:0, then 15:8, then 23:16, then 31:24, one byte per cycle on card_wr_stb. Each byte lowers the count by one. When the count reaches zero mid-word, the unsent bytes of that word are discarded.
- R7: A run is triggered by a read of the data register (address 5), a write of the data register, a write of the config register (address 0) or a write of the block-count register. A run ends by itself.
- R8: A run that ends with the count at zero sets status bit 0 (data flag) and forces debug bits 3:0 to 1.
- R9: On that same completion, status bit 8 is set if config bit 4 is 1. Status bit 10 is set if cmd_busy and config bit 10 are 1. Status bit 9 is set if cmd_write and config bit 8 are 1.
- R10: irq is the OR of status bits 10, 9 and 8. Writing the status register (address 1) clears each bit written as 1.
- R11: Debug bits 8:4 always read the FIFO fill level. A debug write (address 2) whose bits 3:0 are 0xF is stored with bits 3:0 cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops on the data address) |
| reg_addr | input | 3 | Register select: 0 config, 1 status, 2 debug, 3 block size, 4 block count, 5 data |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the selected register |
| cmd_read | input | 1 | Current command transfers from the card |
| cmd_write | input | 1 | Current command transfers to the card |
| cmd_busy | input | 1 | Current command waits on card busy |
| card_rdy | input | 1 | Card has a read byte available |
| card_byte | input | 8 | Card read byte |
| card_take | output | 1 | Card read byte is consumed at this edge |
| card_wr_stb | output | 1 | card_wr_byte is valid and consumed at this edge |
| card_wr_byte | output | 8 | Byte sent to the card |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with its default parameters: a 16-word FIFO, a 12-bit block size and a 9-bit block count. Random transfers of up to about 144 bytes therefore run well past what the FIFO can hold, so a read run must stop on a full FIFO and resume on each data pop. Random write lengths also end on every byte lane, so the partial-word flush and the discard of leftover bytes are both reached. The 16-entry depth is small enough for a directed overflow test, which pushes 17 words and drains the FIFO past empty.

// File: rtl/sdx_pkg.sv
`timescale 1ns/1ps
package sdx_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_RUN_RD = 2'd1,
        ST_RUN_WR = 2'd2,
        ST_FINISH = 2'd3
    } xfer_state_e;

    localparam logic [2:0] A_CFG   = 3'd0;
    localparam logic [2:0] A_STAT  = 3'd1;
    localparam logic [2:0] A_DBG   = 3'd2;
    localparam logic [2:0] A_BSIZE = 3'd3;
    localparam logic [2:0] A_BCNT  = 3'd4;
    localparam logic [2:0] A_DATA  = 3'd5;

    localparam int STAT_W      = 11;
    localparam int ST_DATA_BIT = 0;
    localparam int ST_SDIO_BIT = 8;
    localparam int ST_BLK_BIT  = 9;
    localparam int ST_BUSY_BIT = 10;

    localparam int CFG_DATA_IE = 4;
    localparam int CFG_BLK_IE  = 8;
    localparam int CFG_BUSY_IE = 10;

    localparam logic [31:0] DBG_RESET  = 32'h0000_C60F;
    localparam logic [3:0]  DBG_ST_DAT = 4'h1;
    localparam logic [3:0]  DBG_ST_OFF = 4'hF;
endpackage

// File: rtl/sdx_fifo.sv
`timescale 1ns/1ps
module sdx_fifo #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 32,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int LEN_W = PTR_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] head_data,
    output logic [LEN_W-1:0] fill
);
    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] head_q;
    logic [LEN_W-1:0] len_q;
    logic             do_push;
    logic             do_pop;
    logic [PTR_W-1:0] tail;

    assign do_push   = push && (len_q < LEN_W'(DEPTH));
    assign do_pop    = pop && (len_q != '0);
    assign tail      = head_q + PTR_W'(len_q);
    assign head_data = (len_q != '0) ? mem[head_q] : '0;
    assign fill      = len_q;

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[tail] <= push_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_q <= '0;
            len_q  <= '0;
        end else begin
            if (do_pop) begin
                head_q <= head_q + PTR_W'(1);
            end
            case ({do_push, do_pop})
                2'b10:   len_q <= len_q + LEN_W'(1);
                2'b01:   len_q <= len_q - LEN_W'(1);
                default: len_q <= len_q;
            endcase
        end
    end

    // R2: the fill level never exceeds the depth
    p_len_max_r2: assert property (@(posedge clk) disable iff (!rst_n)
        len_q <= LEN_W'(DEPTH));
    // R2: a push into a full FIFO leaves the level unchanged
    p_full_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop && len_q == LEN_W'(DEPTH)) |=> $stable(len_q));
    // R2: a pop from an empty FIFO leaves it empty
    p_empty_pop_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push && len_q == '0) |=> (len_q == '0));
endmodule

// File: rtl/sdx_engine.sv
`timescale 1ns/1ps
module sdx_engine
    import sdx_pkg::*;
#(
    parameter int CNT_W = 21,
    parameter int DEPTH = 16,
    localparam int LEN_W = $clog2(DEPTH) + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             kick,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dir_read,
    input  logic [LEN_W-1:0] fifo_fill,
    input  logic [31:0]      fifo_head,
    input  logic             card_rdy,
    input  logic [7:0]       card_byte,
    output logic             card_take,
    output logic             card_wr_stb,
    output logic [7:0]       card_wr_byte,
    output logic             eng_push,
    output logic [31:0]      eng_push_word,
    output logic             eng_pop,
    output logic             run_read,
    output logic             run_write,
    output logic             done
);
    xfer_state_e      state, nxt;
    logic             pend_q;
    logic [CNT_W-1:0] cnt_q;
    logic [1:0]       nb_q;
    logic [31:0]      acc_q;
    logic [23:0]      hold_q;
    logic             cnt_nz;
    logic             rd_go;
    logic             wr_go;
    logic [31:0]      word_w;

    assign cnt_nz = (cnt_q != '0);
    assign rd_go  = (state == ST_RUN_RD) && cnt_nz && card_rdy
                    && (fifo_fill < LEN_W'(DEPTH));
    assign wr_go  = (state == ST_RUN_WR) && cnt_nz
                    && ((nb_q != 2'd0) || (fifo_fill != '0));
    assign word_w = acc_q | (32'(card_byte) << {nb_q, 3'b000});

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:   if (pend_q) nxt = dir_read ? ST_RUN_RD : ST_RUN_WR;
            ST_RUN_RD: if (!rd_go) nxt = ST_FINISH;
            ST_RUN_WR: if (!wr_go) nxt = ST_FINISH;
            ST_FINISH: nxt = ST_IDLE;
            default:   nxt = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // outputs
    always_comb begin
        card_take     = rd_go;
        card_wr_stb   = wr_go;
        card_wr_byte  = (nb_q == 2'd0) ? fifo_head[7:0] : hold_q[7:0];
        eng_pop       = wr_go && (nb_q == 2'd0);
        eng_push      = (rd_go && nb_q == 2'd3)
                        || ((state == ST_RUN_RD) && !rd_go && nb_q != 2'd0);
        eng_push_word = rd_go ? word_w : acc_q;
        run_read      = (state == ST_RUN_RD);
        run_write     = (state == ST_RUN_WR);
        done          = (state == ST_FINISH) && !cnt_nz;
    end

    // datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
            cnt_q  <= '0;
            nb_q   <= 2'd0;
            acc_q  <= '0;
            hold_q <= '0;
        end else begin
            pend_q <= kick || (pend_q && state != ST_IDLE);
            if (load)               cnt_q <= load_val;
            else if (rd_go || wr_go) cnt_q <= cnt_q - CNT_W'(1);

            if (state == ST_RUN_RD) begin
                if (rd_go && nb_q != 2'd3) begin
                    nb_q  <= nb_q + 2'd1;
                    acc_q <= word_w;
                end else begin
                    nb_q  <= 2'd0;
                    acc_q <= '0;
                end
            end else if (state == ST_RUN_WR) begin
                if (wr_go) begin
                    if (nb_q == 2'd0) begin
                        hold_q <= fifo_head[31:8];
                        nb_q   <= 2'd3;
                    end else begin
                        hold_q <= {8'h00, hold_q[23:8]};
                        nb_q   <= nb_q - 2'd1;
                    end
                end else begin
                    nb_q <= 2'd0;
                end
            end
        end
    end

    // R6: each byte sent lowers the count by one
    p_count_dec_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (card_wr_stb && !load) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));
    // R4: no packed bytes survive past the end of a run
    p_flush_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FINISH) |-> (nb_q == 2'd0));
    // R5: no card byte is taken outside a read run
    p_take_in_run_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_RUN_RD) |-> !card_take);
    // R6: the two card directions never act together
    p_one_dir_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(card_take && card_wr_stb));
endmodule

// File: rtl/sd_fifo_xfer.sv
`timescale 1ns/1ps
module sd_fifo_xfer
    import sdx_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int BSZ_W = 12,
    parameter int BCT_W = 9
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic        reg_rd,
    input  logic [2:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic        cmd_read,
    input  logic        cmd_write,
    input  logic        cmd_busy,
    input  logic        card_rdy,
    input  logic [7:0]  card_byte,
    output logic        card_take,
    output logic        card_wr_stb,
    output logic [7:0]  card_wr_byte,
    output logic        irq
);
    localparam int CNT_W = BSZ_W + BCT_W;
    localparam int LEN_W = $clog2(DEPTH) + 1;

    logic [31:0]       cfg_q;
    logic [STAT_W-1:0] stat_q;
    logic [31:0]       dbg_q;
    logic [BSZ_W-1:0]  bsize_q;
    logic [BCT_W-1:0]  bcnt_q;

    logic              wr_cfg, wr_stat, wr_dbg, wr_bsize, wr_bcnt, wr_data, rd_data;
    logic              kick;
    logic [CNT_W-1:0]  load_val;
    logic [LEN_W-1:0]  fill;
    logic [31:0]       head;
    logic              eng_push, eng_pop, run_read, run_write, done;
    logic [31:0]       eng_word;
    logic              f_push, f_pop;
    logic [31:0]       f_word;
    logic [STAT_W-1:0] stat_set;
    logic [31:0]       dbg_in;

    assign wr_cfg   = reg_wr && reg_addr == A_CFG;
    assign wr_stat  = reg_wr && reg_addr == A_STAT;
    assign wr_dbg   = reg_wr && reg_addr == A_DBG;
    assign wr_bsize = reg_wr && reg_addr == A_BSIZE;
    assign wr_bcnt  = reg_wr && reg_addr == A_BCNT;
    assign wr_data  = reg_wr && reg_addr == A_DATA;
    assign rd_data  = reg_rd && reg_addr == A_DATA;
    assign kick     = wr_cfg || wr_bcnt || wr_data || rd_data;
    assign load_val = CNT_W'(bsize_q) * CNT_W'(reg_wdata[BCT_W-1:0]);

    // the engine owns the FIFO side it drives during a run
    assign f_push = run_read  ? eng_push : wr_data;
    assign f_word = run_read  ? eng_word : reg_wdata;
    assign f_pop  = run_write ? eng_pop  : rd_data;

    sdx_fifo #(.DEPTH(DEPTH), .WIDTH(32)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (f_push),
        .push_data (f_word),
        .pop       (f_pop),
        .head_data (head),
        .fill      (fill)
    );

    sdx_engine #(.CNT_W(CNT_W), .DEPTH(DEPTH)) u_eng (
        .clk           (clk),
        .rst_n         (rst_n),
        .kick          (kick),
        .load          (wr_bcnt),
        .load_val      (load_val),
        .dir_read      (cmd_read),
        .fifo_fill     (fill),
        .fifo_head     (head),
        .card_rdy      (card_rdy),
        .card_byte     (card_byte),
        .card_take     (card_take),
        .card_wr_stb   (card_wr_stb),
        .card_wr_byte  (card_wr_byte),
        .eng_push      (eng_push),
        .eng_push_word (eng_word),
        .eng_pop       (eng_pop),
        .run_read      (run_read),
        .run_write     (run_write),
        .done          (done)
    );

    always_comb begin
        stat_set = '0;
        if (done) begin
            stat_set[ST_DATA_BIT] = 1'b1;
            stat_set[ST_SDIO_BIT] = cfg_q[CFG_DATA_IE];
            stat_set[ST_BUSY_BIT] = cmd_busy && cfg_q[CFG_BUSY_IE];
            stat_set[ST_BLK_BIT]  = cmd_write && cfg_q[CFG_BLK_IE];
        end
        dbg_in = reg_wdata;
        if (reg_wdata[3:0] == DBG_ST_OFF) dbg_in[3:0] = 4'h0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q   <= '0;
            stat_q  <= '0;
            dbg_q   <= DBG_RESET;
            bsize_q <= '0;
            bcnt_q  <= '0;
        end else begin
            if (wr_cfg)   cfg_q   <= reg_wdata;
            if (wr_bsize) bsize_q <= reg_wdata[BSZ_W-1:0];
            if (wr_bcnt)  bcnt_q  <= reg_wdata[BCT_W-1:0];
            stat_q <= (stat_q & ~(wr_stat ? reg_wdata[STAT_W-1:0] : '0)) | stat_set;
            if (wr_dbg)    dbg_q <= dbg_in;
            else if (done) dbg_q[3:0] <= DBG_ST_DAT;
        end
    end

    always_comb begin
        unique case (reg_addr)
            A_CFG:   reg_rdata = cfg_q;
            A_STAT:  reg_rdata = 32'(stat_q);
            A_DBG:   reg_rdata = {dbg_q[31:9], 5'(fill), dbg_q[3:0]};
            A_BSIZE: reg_rdata = 32'(bsize_q);
            A_BCNT:  reg_rdata = 32'(bcnt_q);
            A_DATA:  reg_rdata = head;
            default: reg_rdata = '0;
        endcase
    end

    assign irq = stat_q[ST_BUSY_BIT] | stat_q[ST_BLK_BIT] | stat_q[ST_SDIO_BIT];

    // R10: writing all ones to status with no completion clears it
    p_w1c_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stat && reg_wdata[STAT_W-1:0] == '1 && !done) |=> (stat_q == '0));
    // R8: completion leaves the data flag set and the state code at data mode
    p_done_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !wr_dbg) |=> (stat_q[ST_DATA_BIT] && dbg_q[3:0] == DBG_ST_DAT));
    // R11: a stored state field is never the power-off code after a debug write
    p_dbg_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
        wr_dbg |=> (dbg_q[3:0] != DBG_ST_OFF));
endmodule

// File: tb/sd_fifo_xfer_tb.sv
`timescale 1ns/1ps
module sd_fifo_xfer_tb;
    localparam int SETTLE = 72;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        cmd_read = 1'b0, cmd_write = 1'b0, cmd_busy = 1'b0;
    logic        card_rdy = 1'b1;
    logic [7:0]  card_byte;
    logic        card_take, card_wr_stb, irq;
    logic [7:0]  card_wr_byte;

    int nchk = 0, nerr = 0;
    bit finished = 1'b0;
    int src_idx = 0;

    // model state
    logic [31:0] mq[$];
    logic [7:0]  exp_b[$];
    logic [7:0]  got_b[$];
    int          m_src = 0;
    int          m_cnt = 0;
    int          m_bsz = 0;
    logic [31:0] m_cfg = '0;
    logic [10:0] m_stat = '0;
    logic [31:0] m_dbg = 32'h0000_C60F;
    bit          m_rdy = 1'b1;

    always #4 clk = ~clk;   // 125 MHz

    sd_fifo_xfer u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .cmd_read(cmd_read), .cmd_write(cmd_write), .cmd_busy(cmd_busy),
        .card_rdy(card_rdy), .card_byte(card_byte), .card_take(card_take),
        .card_wr_stb(card_wr_stb), .card_wr_byte(card_wr_byte), .irq(irq)
    );

    function automatic logic [7:0] src_byte(int k);
        return 8'((k * 37 + 11) & 255);
    endfunction

    assign card_byte = src_byte(src_idx);
    always @(posedge clk) if (card_take) src_idx <= src_idx + 1;
    always @(negedge clk) if (card_wr_stb) got_b.push_back(card_wr_byte);

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [2:0] a, logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        #2 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    function automatic void m_push(logic [31:0] w);
        if (mq.size() < 16) mq.push_back(w);
    endfunction

    function automatic void m_run();
        int n = 0;
        logic [31:0] v = '0;
        if (cmd_read) begin
            while (m_cnt != 0 && m_rdy && mq.size() < 16) begin
                v |= 32'(src_byte(m_src)) << (8 * n);
                m_src++; m_cnt--; n++;
                if (n == 4) begin m_push(v); n = 0; v = '0; end
            end
            if (n != 0) m_push(v);
        end else begin
            while (m_cnt > 0 && (mq.size() > 0 || n > 0)) begin
                if (n == 0) begin v = mq.pop_front(); n = 4; end
                n--; m_cnt--;
                exp_b.push_back(v[7:0]);
                v = v >> 8;
            end
        end
        if (m_cnt == 0) begin
            m_stat[0] = 1'b1;
            if (m_cfg[4]) m_stat[8] = 1'b1;
            if (cmd_busy && m_cfg[10]) m_stat[10] = 1'b1;
            if (cmd_write && m_cfg[8]) m_stat[9] = 1'b1;
            m_dbg[3:0] = 4'h1;
        end
    endfunction

    task automatic settle();
        repeat (SETTLE) @(negedge clk);
    endtask

    task automatic op_cfg(logic [31:0] v);  // R7
        wr(3'd0, v); m_cfg = v; m_run(); settle();
    endtask
    task automatic op_bsize(int s);
        wr(3'd3, 32'(s)); m_bsz = s;
    endtask
    task automatic op_bcnt(int b);          // R3
        wr(3'd4, 32'(b)); m_cnt = m_bsz * b; m_run(); settle();
    endtask
    task automatic op_push(logic [31:0] w); // R7
        wr(3'd5, w); m_push(w); m_run(); settle();
    endtask
    task automatic op_pop(string tag);      // R2 R4
        logic [31:0] d, e;
        rd(3'd5, d);
        e = (mq.size() > 0) ? mq.pop_front() : 32'h0;
        chk(tag, d, e);
        m_run(); settle();
    endtask
    task automatic op_clear(logic [31:0] m); // R10
        wr(3'd1, m); m_stat &= ~m[10:0];
    endtask

    task automatic check_state(string tag);
        logic [31:0] d;
        bit bad = 0;
        rd(3'd1, d);
        chk({tag, " R8 R9 status"}, d, 32'(m_stat));
        rd(3'd2, d);
        chk({tag, " R11 debug"}, d, (m_dbg & ~32'h1F0) | (32'(mq.size()) << 4));
        chk({tag, " R10 irq"}, 32'(irq), 32'(|m_stat[10:8]));
        if (got_b.size() != exp_b.size()) bad = 1;
        else foreach (got_b[i]) if (got_b[i] !== exp_b[i]) bad = 1;
        chk({tag, " R6 card bytes"}, 32'(got_b.size()) | (bad ? 32'h8000_0000 : 0),
            32'(exp_b.size()));
        got_b.delete(); exp_b.delete();
    endtask

    task automatic set_cmd(bit r, bit w, bit b);
        @(negedge clk);
        cmd_read = r; cmd_write = w; cmd_busy = b;
    endtask

    initial begin
        logic [31:0] d;
        void'($urandom(32'h5D17));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset values
        rd(3'd1, d); chk("R1 status", d, 32'h0);
        rd(3'd2, d); chk("R1 debug", d, 32'h0000_C60F);
        chk("R1 irq", 32'(irq), 32'h0);
        chk("R1 card strobes", {30'h0, card_take, card_wr_stb}, 32'h0);

        // R11: power-off state code is stored as zero
        wr(3'd2, 32'hABCD_E12F); m_dbg = 32'hABCD_E120;
        rd(3'd2, d); chk("R11 off code", d, 32'hABCD_E000);
        wr(3'd2, 32'h0000_C605); m_dbg = 32'h0000_C605;
        rd(3'd2, d); chk("R11 plain write", d, 32'h0000_C605);

        // R2: overflow and underflow in write mode with a zero count
        set_cmd(0, 1, 0);
        for (int i = 0; i < 17; i++) op_push(32'h1000_0000 + 32'(i));
        check_state("R2 full");
        for (int i = 0; i < 17; i++) op_pop("R2 drain");
        check_state("R2 empty");
        op_clear(32'h7FF);

        // R4: partial trailing word in read mode
        set_cmd(1, 0, 0);
        op_bsize(6); op_bcnt(1);
        check_state("R4 partial");
        op_pop("R4 word0"); op_pop("R4 word1");
        op_clear(32'h7FF);

        // R5: stalled card, no progress until a trigger
        @(negedge clk); card_rdy = 1'b0; m_rdy = 0;
        op_bsize(8); op_bcnt(1);
        check_state("R5 stalled");
        @(negedge clk); card_rdy = 1'b1; m_rdy = 1;
        settle();
        check_state("R5 ready no trigger");
        op_cfg(32'h0000_0010);
        check_state("R5 resumed by config");
        op_pop("R5 word0"); op_pop("R5 word1");
        op_clear(32'h7FF);

        // R6 R9: write with discarded tail, all interrupt causes enabled
        set_cmd(0, 1, 1);
        op_cfg(32'h0000_0510);
        op_clear(32'h7FF);
        op_bsize(10); op_bcnt(1);
        op_push(32'h4433_2211); op_push(32'h8877_6655); op_push(32'hCCBB_AA99);
        check_state("R6 R9 write");
        op_clear(32'h100);
        check_state("R10 partial clear");
        op_clear(32'h7FF);
        check_state("R10 full clear");

        // random transfers
        for (int it = 0; it < 20; it++) begin
            bit rmode = 1'($urandom_range(0, 1));
            int guard = 0;
            set_cmd(rmode, !rmode, 1'($urandom_range(0, 1)));
            op_cfg($urandom & 32'h0000_0510);
            op_clear(32'h7FF);
            op_bsize($urandom_range(1, 48));
            op_bcnt($urandom_range(1, 3));
            if (rmode) begin
                while ((mq.size() > 0 || m_cnt > 0) && guard < 80) begin
                    op_pop("R4 random read"); guard++;
                end
            end else begin
                while (m_cnt > 0 && guard < 80) begin
                    op_push($urandom); guard++;
                end
                while (mq.size() > 0) op_pop("R2 random drain");
            end
            check_state("R3 random end");
        end

        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            nchk++; nerr++;
            $display("FAIL watchdog R7 actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end
endmodule